// File: doc/BRIEF.md
# Password-Protected Clock Divider

This block derives a slow, regular timing strobe for a peripheral such as a PWM unit from a fast clock. It does not create a second clock domain. It picks one of several source-qualifier inputs and counts the cycles in which that source is active. Every N counted cycles it emits a single-cycle enable pulse, so all downstream logic stays on the one clock.

Software controls the block through two 32-bit registers. The control register holds the source select, a run enable, a kill request and a read-only busy flag. The divisor register holds the integer N.

A write lands only when its top byte carries the key value 0x5A. Any other key leaves both registers exactly as they were. The busy flag supports a safe stop/start sequence:
- After setting enable, software sees busy rise with the first output pulse.
- After clearing enable, busy falls at the end of the period in progress.
- The divisor and the source select accept new values only while busy is low. A running consumer therefore never sees a period of mixed length.

Top module: `cdiv_top`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A changes neither the control register nor the divisor register.
- R2: Control register layout: bits 3:0 are the source select, bit 4 is enable, bit 5 is kill and bit 7 is busy (read-only). All other bits read as 0, and writing bit 7 has no effect.
- R3: The divisor register holds the unsigned integer N in bits 23:12, reads back there, and all its other bits read as 0. It is selected with wr_sel = 1; the control register is selected with wr_sel = 0.
- R4: While running, the output is a single-cycle pulse once every N cycles in which the selected source is active. With a source that is active in every cycle, the first pulse comes N+1 cycles after the cycle in which the enabling write is clocked in.
- R5: A divisor of 0 or 1 gives a pulse on every active source cycle.
- R6: Busy is low from the enabling write until the first output pulse, and rises together with that pulse.
- R7: After enable is cleared, exactly the period in progress completes. Busy falls together with its final pulse, which comes within N cycles of the write, and no pulse follows.
- R8: Kill stops the generator one cycle after the write lands: no pulse, busy low, count cleared, for as long as kill is set. After kill is cleared with enable set, the first pulse again comes N+1 cycles after the write.
- R9: While busy is high, divisor writes and the source-select field of control writes are ignored. The enable and kill bits are still accepted.
- R10: The divider counts only the cycles in which src_in[select] is high. A source that is high every other cycle therefore gives a pulse interval of 2N cycles.
- R11: After reset both registers read 0, busy is low and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = divisor register |
| wr_data | input | 32 | Write data; bits 31:24 carry the key |
| src_in | input | 16 | Per-source activity qualifiers |
| rd_ctrl | output | 32 | Control register read value including busy |
| rd_div | output | 32 | Divisor register read value |
| tick_o | output | 1 | Divided single-cycle enable pulse |

## Verification
The hardest situations to reach from the ports are writes that land at a particular phase of a running period. These include a divisor or source change issued while busy, and an enable-clear that arrives either on a pulse cycle or partway through one. The stimulus sweeps several divisors, including 0, 1 and a 16-cycle value. For each one it first locks onto the pulse train by waiting for pulses, then issues the protected writes at a known offset from the last pulse. It then measures the remaining period, the position of the final pulse and the silence that follows. A second source that is active only every other cycle checks that only qualified cycles are counted.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // write key and where it sits in a register write
  localparam logic [7:0] CDIV_KEY   = 8'h5A;
  localparam int         KEY_LSB    = 24;

  // control register bit positions
  localparam int         ENAB_BIT   = 4;
  localparam int         KILL_BIT   = 5;
  localparam int         BUSY_BIT   = 7;

  // divisor field position
  localparam int         DIV_LSB    = 12;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_DIV  = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    GEN_STOP = 2'd0,   // held, counter cleared
    GEN_ARM  = 2'd1,   // counting toward first pulse, not yet busy
    GEN_RUN  = 2'd2    // steady running, busy reported
  } gen_state_e;
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int SRC_W = 4,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             busy_i,
  output logic [SRC_W-1:0] src_o,
  output logic             enab_o,
  output logic             kill_o,
  output logic [DIV_W-1:0] div_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic key_ok, wr_ctrl, wr_div;
  logic unused_wdata;

  assign key_ok       = (wr_data[KEY_LSB +: 8] == CDIV_KEY);
  assign wr_ctrl      = wr_en && key_ok && (reg_sel_e'(wr_sel) == REG_CTRL);
  assign wr_div       = wr_en && key_ok && (reg_sel_e'(wr_sel) == REG_DIV);
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o  <= '0;
      enab_o <= 1'b0;
      kill_o <= 1'b0;
      div_o  <= '0;
    end else begin
      if (wr_ctrl) begin
        enab_o <= wr_data[ENAB_BIT];
        kill_o <= wr_data[KILL_BIT];
        if (!busy_i) src_o <= wr_data[SRC_W-1:0];
      end
      if (wr_div && !busy_i) div_o <= wr_data[DIV_LSB +: DIV_W];
    end
  end

  // R1: a write without the key leaves every register field untouched
  p_key_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok) |=> ($stable(src_o) && $stable(enab_o) && $stable(kill_o) && $stable(div_o)))
    else $error("p_key_gate_r1");

  // R9: divisor frozen while busy
  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(div_o))
    else $error("p_div_hold_r9");

  // R9: source select frozen while busy
  p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(src_o))
    else $error("p_src_hold_r9");
endmodule

// File: rtl/cdiv_srcsel.sv
module cdiv_srcsel #(
  parameter int SRC_W = 4,
  localparam int NSRC = 1 << SRC_W
) (
  input  logic [NSRC-1:0]  src_in,
  input  logic [SRC_W-1:0] sel_i,
  output logic             active_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [NSRC-1:0] hit;

  // one-hot gate per source, OR-reduced
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_in[g] && (sel_i == SRC_W'(g));
  end

  assign active_o = |hit;
endmodule

// File: rtl/cdiv_gen.sv
module cdiv_gen
  import cdiv_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             enab_i,
  input  logic             kill_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             busy_o
);
  timeunit 1ns;
  timeprecision 1ps;

  gen_state_e       state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;
  logic             terminal;

  // divisors 0 and 1 both mean pass-through
  assign last_cnt = (div_i <= DIV_W'(1)) ? '0 : div_i - DIV_W'(1);
  assign terminal = (cnt_q >= last_cnt);
  assign busy_o   = (state_q == GEN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GEN_STOP;
      cnt_q   <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (kill_i) begin
        state_q <= GEN_STOP;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          GEN_STOP: begin
            cnt_q <= '0;
            if (enab_i) state_q <= GEN_ARM;
          end
          default: begin
            if (active_i) begin
              if (terminal) begin
                cnt_q   <= '0;
                tick_o  <= 1'b1;
                state_q <= enab_i ? GEN_RUN : GEN_STOP;
              end else begin
                cnt_q <= cnt_q + DIV_W'(1);
              end
            end
          end
        endcase
      end
    end
  end

  // R6: busy only rises together with a pulse
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> tick_o)
    else $error("p_busy_rise_r6");

  // R7: busy falls with the last pulse unless kill forced it
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (tick_o || $past(kill_i)))
    else $error("p_busy_fall_r7");

  // R8: kill silences the output next cycle
  p_kill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (!tick_o && !busy_o))
    else $error("p_kill_quiet_r8");

  // R10: a pulse always follows a qualified source cycle
  p_tick_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(active_i))
    else $error("p_tick_src_r10");
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
  import cdiv_pkg::*;
#(
  parameter int SRC_W = 4,
  parameter int DIV_W = 12,
  localparam int NSRC = 1 << SRC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [NSRC-1:0] src_in,
  output logic [31:0]     rd_ctrl,
  output logic [31:0]     rd_div,
  output logic            tick_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SRC_W-1:0] src_sel;
  logic             enab, kill, busy, active;
  logic [DIV_W-1:0] div_val;

  cdiv_regs #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .busy_i  (busy),
    .src_o   (src_sel),
    .enab_o  (enab),
    .kill_o  (kill),
    .div_o   (div_val)
  );

  cdiv_srcsel #(.SRC_W(SRC_W)) u_srcsel (
    .src_in   (src_in),
    .sel_i    (src_sel),
    .active_o (active)
  );

  cdiv_gen #(.DIV_W(DIV_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .enab_i   (enab),
    .kill_i   (kill),
    .div_i    (div_val),
    .tick_o   (tick_o),
    .busy_o   (busy)
  );

  always_comb begin
    rd_ctrl                     = '0;
    rd_ctrl[SRC_W-1:0]          = src_sel;
    rd_ctrl[ENAB_BIT]           = enab;
    rd_ctrl[KILL_BIT]           = kill;
    rd_ctrl[BUSY_BIT]           = busy;
    rd_div                      = '0;
    rd_div[DIV_LSB +: DIV_W]    = div_val;
  end
endmodule

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SRC_W = 4;
  localparam int DIV_W = 12;
  localparam int NSRC  = 1 << SRC_W;
  localparam logic [7:0] KEY = 8'h5A;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            wr_sel = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [NSRC-1:0] src_in;
  logic            src_alt = 1'b0;
  logic [31:0]     rd_ctrl, rd_div;
  logic            tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cdiv_top #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_in(src_in), .rd_ctrl(rd_ctrl), .rd_div(rd_div), .tick_o(tick)
  );

  always #2 clk = ~clk;

  always_comb begin
    src_in    = '0;
    src_in[6] = 1'b1;      // always-active source
    src_in[2] = src_alt;   // active every other cycle
  end

  initial forever begin
    @(negedge clk);
    src_alt = ~src_alt;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] key, input logic [23:0] body);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = {key, body};
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_tick(input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k < limit);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  task automatic stop_and_drain();
    int k;
    wr(1'b0, KEY, 24'h000006);
    k = 0;
    while (rd_ctrl[7] && k < 100) begin
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int k, n, neff;
    int divs[7] = '{0, 1, 2, 3, 5, 7, 16};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(rd_ctrl == 32'h0, "R11 ctrl after reset", rd_ctrl, 0);
    chk(rd_div == 32'h0, "R11 div after reset", rd_div, 0);
    chk(tick == 1'b0, "R11 no pulse after reset", tick, 0);

    // R1 wrong key on both registers
    wr(1'b1, 8'hA5, 24'(5) << 12);
    chk(rd_div == 32'h0, "R1 div unchanged by bad key", rd_div, 0);
    wr(1'b0, 8'h5B, 24'h000016);
    chk(rd_ctrl == 32'h0, "R1 ctrl unchanged by bad key", rd_ctrl, 0);
    count_ticks(40, n);
    chk(n == 0, "R1 no pulses after bad-key enable", n, 0);

    // R2 reserved bits and busy bit are not writable
    wr(1'b0, KEY, 24'hFFFFC6);
    chk(rd_ctrl == 32'h6, "R2 ctrl layout readback", rd_ctrl, 6);

    // R3..R7, R9 sweep over divisors with the always-active source
    foreach (divs[i]) begin
      neff = (divs[i] < 2) ? 1 : divs[i];
      wr(1'b1, KEY, 24'(divs[i]) << 12);
      chk(rd_div == (32'(divs[i]) << 12), "R3 divisor readback", rd_div, 32'(divs[i]) << 12);
      wr(1'b0, KEY, 24'h000016);
      chk(rd_ctrl == 32'h16, "R2 enable readback", rd_ctrl, 32'h16);
      chk(rd_ctrl[7] == 1'b0, "R6 busy low before first pulse", rd_ctrl[7], 0);
      wait_tick(neff + 10, k);
      chk(k == neff + 1, "R4 first pulse delay", k, neff + 1);
      chk(rd_ctrl[7] == 1'b1, "R6 busy with first pulse", rd_ctrl[7], 1);
      for (int r = 0; r < 3; r++) begin
        wait_tick(neff + 10, k);
        chk(k == neff, (divs[i] < 2) ? "R5 pass-through period" : "R4 period", k, neff);
      end
      // R9 writes while busy
      wr(1'b1, KEY, 24'(divs[i] + 3) << 12);
      chk(rd_div == (32'(divs[i]) << 12), "R9 divisor held while busy", rd_div, 32'(divs[i]) << 12);
      wr(1'b0, KEY, 24'h000012);
      chk(rd_ctrl[3:0] == 4'd6, "R9 source held while busy", rd_ctrl[3:0], 6);
      wait_tick(neff + 10, k);
      wait_tick(neff + 10, k);
      chk(k == neff, "R9 period unchanged", k, neff);
      // R7 orderly stop
      wr(1'b0, KEY, 24'h000006);
      k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!(tick && !rd_ctrl[7]) && k < 2 * neff + 4);
      chk(tick && !rd_ctrl[7], "R7 busy falls with final pulse", {tick, rd_ctrl[7]}, 2);
      chk(k <= neff, "R7 final pulse within one period", k, neff);
      count_ticks(3 * neff + 5, n);
      chk(n == 0, "R7 no pulse after stop", n, 0);
      chk(rd_ctrl[7] == 1'b0, "R7 busy stays low", rd_ctrl[7], 0);
    end

    // R10 half-rate source
    foreach (divs[i]) begin
      if (divs[i] == 1 || divs[i] == 3) begin
        wr(1'b1, KEY, 24'(divs[i]) << 12);
        wr(1'b0, KEY, 24'h000012);
        chk(rd_ctrl[3:0] == 4'd2, "R10 source select accepted when idle", rd_ctrl[3:0], 2);
        wait_tick(4 * divs[i] + 10, k);
        for (int r = 0; r < 3; r++) begin
          wait_tick(4 * divs[i] + 10, k);
          chk(k == 2 * divs[i], "R10 half-rate source period", k, 2 * divs[i]);
        end
        stop_and_drain();
      end
    end

    // R8 kill and restart
    wr(1'b0, KEY, 24'h000006);
    wr(1'b1, KEY, 24'(4) << 12);
    wr(1'b0, KEY, 24'h000016);
    wait_tick(20, k);
    chk(k == 5, "R8 pre-kill first pulse", k, 5);
    wait_tick(2, k);
    wr(1'b0, KEY, 24'h000036);
    @(negedge clk);
    chk(!tick && !rd_ctrl[7], "R8 stopped one cycle after kill", {tick, rd_ctrl[7]}, 0);
    chk(rd_ctrl[5] == 1'b1, "R8 kill readback", rd_ctrl[5], 1);
    count_ticks(30, n);
    chk(n == 0, "R8 no pulses while killed", n, 0);
    wr(1'b0, KEY, 24'h000016);
    wait_tick(20, k);
    chk(k == 5, "R8 restart first pulse delay", k, 5);
    stop_and_drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule